// File: doc/BRIEF.md
# BCD Seven-Segment Latching Decoder

This block turns one binary-coded decimal digit into the seven segment drive signals of a numeric display. A 4-bit storage register sits in front of the decoder. It follows the digit input on every rising clock edge while the hold input is low. While hold is high it keeps the last value it captured, so the display stays steady whatever the digit bus does.

Two active-low overrides act on the decoded segments after the storage register and never write into it. Lamp test lights every segment and wins over all other inputs. Blank turns every segment off when lamp test is inactive. Codes above nine decode to a dark display. Six is drawn without its top bar and nine without its bottom bar. A second copy of the segment vector, registered one clock later, is also provided so that a downstream path can start from a flop.

Top module: `bcd_seg_latch`

## Requirements
- R1: On a rising clock edge where `hold_i` is low, the storage register loads `digit_i`, and `seg_o` shows the decoded new value after that edge.
- R2: On a rising clock edge where `hold_i` is high, the storage register keeps its value, and changes on `digit_i` do not reach `seg_o`.
- R3: While `lamp_test_n_i` is low, `seg_o` is 7'h7F, whatever the other inputs and the stored value are.
- R4: While `lamp_test_n_i` is high and `blank_n_i` is low, `seg_o` is 7'h00.
- R5: `seg_o` bit 0 drives segment a (top), bit 1 b (upper right), bit 2 c (lower right), bit 3 d (bottom), bit 4 e (lower left), bit 5 f (upper left), bit 6 g (middle). With both overrides inactive, stored digits 0 to 9 give 7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7C, 7'h07, 7'h7F, 7'h67.
- R6: With both overrides inactive, stored codes 10 to 15 give 7'h00.
- R7: Lamp test and blank never change the stored value: after they are released, `seg_o` shows the value held before they were asserted.
- R8: `seg_q_o` equals the value `seg_o` had in the previous clock cycle.
- R9: While `rst_n` is low the stored value is 0 and `seg_q_o` is 7'h00; with both overrides inactive, `seg_o` then shows 7'h3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| digit_i | input | 4 | BCD digit to capture |
| hold_i | input | 1 | High keeps the stored digit, low lets it follow `digit_i` |
| lamp_test_n_i | input | 1 | Active-low lamp test, all segments on |
| blank_n_i | input | 1 | Active-low blank, all segments off |
| seg_o | output | 7 | Segment vector, bit 0 = a to bit 6 = g, active high |
| seg_q_o | output | 7 | `seg_o` delayed by one clock |

## Verification
The bench sweeps every combination of lamp test, blank and the sixteen codes, so a swapped segment bit, a tail added to six or nine, or an invalid code that lights something shows up against an independently built table. It loads a digit, raises hold, changes the bus and then pulses both overrides; a design that let the overrides write the register, or that still sampled the bus under hold, would show the wrong digit once everything is released. A wrong priority, letting blank beat lamp test, would give a dark display where all segments should be lit. The delayed output is compared one cycle after each change, which catches a missing or doubled pipeline stage.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned MAX_DEC = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  localparam seg_t SEG_ALL_ON  = {SEG_W{1'b1}};
  localparam seg_t SEG_ALL_OFF = {SEG_W{1'b0}};
endpackage

// File: rtl/bcd_digit_store.sv
module bcd_digit_store
  import bcd_seg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold_i,
  input  digit_t digit_i,
  output digit_t stored_o
);
  digit_t store_q;
  digit_t store_d;
  logic   load_en;

  assign load_en = ~hold_i;

  always_comb begin
    store_d = store_q;
    if (load_en) begin
      store_d = digit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else begin
      store_q <= store_d;
    end
  end

  assign stored_o = store_q;
endmodule

// File: rtl/bcd_seg_decode.sv
module bcd_seg_decode
  import bcd_seg_pkg::*;
(
  input  digit_t code_i,
  output seg_t   seg_o
);
  // bit order g f e d c b a
  always_comb begin
    unique case (code_i)
      4'd0:    seg_o = 7'b0111111;
      4'd1:    seg_o = 7'b0000110;
      4'd2:    seg_o = 7'b1011011;
      4'd3:    seg_o = 7'b1001111;
      4'd4:    seg_o = 7'b1100110;
      4'd5:    seg_o = 7'b1101101;
      4'd6:    seg_o = 7'b1111100;
      4'd7:    seg_o = 7'b0000111;
      4'd8:    seg_o = 7'b1111111;
      4'd9:    seg_o = 7'b1100111;
      default: seg_o = SEG_ALL_OFF;
    endcase
  end
endmodule

// File: rtl/bcd_seg_override.sv
module bcd_seg_override
  import bcd_seg_pkg::*;
(
  input  seg_t seg_i,
  input  logic lamp_test_n_i,
  input  logic blank_n_i,
  output seg_t seg_o
);
  always_comb begin
    if (!lamp_test_n_i) begin
      seg_o = SEG_ALL_ON;
    end else if (!blank_n_i) begin
      seg_o = SEG_ALL_OFF;
    end else begin
      seg_o = seg_i;
    end
  end
endmodule

// File: rtl/bcd_seg_latch.sv
module bcd_seg_latch
  import bcd_seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic             hold_i,
  input  logic             lamp_test_n_i,
  input  logic             blank_n_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [SEG_W-1:0] seg_q_o
);
  digit_t stored;
  seg_t   seg_raw;
  seg_t   seg_drv;
  seg_t   seg_pipe_d;
  seg_t   seg_pipe_q;

  bcd_digit_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (hold_i),
    .digit_i  (digit_i),
    .stored_o (stored)
  );

  bcd_seg_decode u_decode (
    .code_i (stored),
    .seg_o  (seg_raw)
  );

  bcd_seg_override u_override (
    .seg_i         (seg_raw),
    .lamp_test_n_i (lamp_test_n_i),
    .blank_n_i     (blank_n_i),
    .seg_o         (seg_drv)
  );

  always_comb begin
    seg_pipe_d = seg_drv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_pipe_q <= SEG_ALL_OFF;
    end else begin
      seg_pipe_q <= seg_pipe_d;
    end
  end

  assign seg_o   = seg_drv;
  assign seg_q_o = seg_pipe_q;
endmodule

// File: rtl/bcd_seg_latch_chk.sv
module bcd_seg_latch_chk
  import bcd_seg_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input digit_t digit_i,
  input logic   hold_i,
  input logic   lamp_test_n_i,
  input logic   blank_n_i,
  input seg_t   seg_o,
  input seg_t   seg_q_o,
  input digit_t stored
);
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> stored == $past(digit_i));

  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(stored));

  a_r3_lamp_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_test_n_i |-> seg_o == SEG_ALL_ON);

  a_r4_blank_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n_i && !blank_n_i) |-> seg_o == SEG_ALL_OFF);

  a_r6_invalid_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n_i && blank_n_i && stored > digit_t'(MAX_DEC)) |-> seg_o == SEG_ALL_OFF);

  a_r8_pipe_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> seg_q_o == $past(seg_o));
endmodule

bind bcd_seg_latch bcd_seg_latch_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .digit_i       (digit_i),
  .hold_i        (hold_i),
  .lamp_test_n_i (lamp_test_n_i),
  .blank_n_i     (blank_n_i),
  .seg_o         (seg_o),
  .seg_q_o       (seg_q_o),
  .stored        (stored)
);

// File: tb/bcd_seg_latch_tb_top.sv
module bcd_seg_latch_tb_top;
  localparam logic [6:0] SA = 7'h01, SB = 7'h02, SC = 7'h04, SD = 7'h08,
                         SE = 7'h10, SF = 7'h20, SG = 7'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit_i = 4'd0;
  logic       hold_i = 1'b0;
  logic       lamp_test_n_i = 1'b1;
  logic       blank_n_i = 1'b1;
  logic [6:0] seg_o;
  logic [6:0] seg_q_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_seg_latch dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .digit_i       (digit_i),
    .hold_i        (hold_i),
    .lamp_test_n_i (lamp_test_n_i),
    .blank_n_i     (blank_n_i),
    .seg_o         (seg_o),
    .seg_q_o       (seg_q_o)
  );

  function automatic logic [6:0] glyph(input logic [3:0] d);
    case (d)
      4'd0: glyph = SA | SB | SC | SD | SE | SF;
      4'd1: glyph = SB | SC;
      4'd2: glyph = SA | SB | SG | SE | SD;
      4'd3: glyph = SA | SB | SG | SC | SD;
      4'd4: glyph = SF | SG | SB | SC;
      4'd5: glyph = SA | SF | SG | SC | SD;
      4'd6: glyph = SF | SE | SD | SC | SG;
      4'd7: glyph = SA | SB | SC;
      4'd8: glyph = SA | SB | SC | SD | SE | SF | SG;
      4'd9: glyph = SA | SB | SC | SF | SG;
      default: glyph = 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg(input logic lt_n, input logic bl_n,
                                            input logic [3:0] d);
    if (!lt_n)      expect_seg = 7'h7F;
    else if (!bl_n) expect_seg = 7'h00;
    else            expect_seg = glyph(d);
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_digit(input logic [3:0] d);
    @(negedge clk);
    hold_i  = 1'b0;
    digit_i = d;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset seg_o", seg_o, 7'h3F);
    check("R9 reset seg_q_o", seg_q_o, 7'h00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep();
    for (int lt = 0; lt < 2; lt++) begin
      for (int bl = 0; bl < 2; bl++) begin
        for (int d = 0; d < 16; d++) begin
          @(negedge clk);
          lamp_test_n_i = lt[0];
          blank_n_i     = bl[0];
          hold_i        = 1'b0;
          digit_i       = d[3:0];
          @(posedge clk);
          #1;
          if (!lt[0])
            check("R3 lamp test", seg_o, expect_seg(lt[0], bl[0], d[3:0]));
          else if (!bl[0])
            check("R4 blank", seg_o, expect_seg(lt[0], bl[0], d[3:0]));
          else if (d > 9)
            check("R6 invalid code", seg_o, expect_seg(lt[0], bl[0], d[3:0]));
          else
            check("R5 R1 decode", seg_o, expect_seg(lt[0], bl[0], d[3:0]));
        end
      end
    end
    @(negedge clk);
    lamp_test_n_i = 1'b1;
    blank_n_i     = 1'b1;
  endtask

  task automatic t_hold();
    load_digit(4'd5);
    check("R1 load 5", seg_o, glyph(4'd5));
    @(negedge clk);
    hold_i  = 1'b1;
    digit_i = 4'd8;
    repeat (3) @(posedge clk);
    #1;
    check("R2 hold ignores bus", seg_o, glyph(4'd5));
    @(negedge clk);
    digit_i = 4'd1;
    @(posedge clk);
    #1;
    check("R2 hold second change", seg_o, glyph(4'd5));
    @(negedge clk);
    hold_i = 1'b0;
    @(posedge clk);
    #1;
    check("R1 release hold", seg_o, glyph(4'd1));
  endtask

  task automatic t_override_keeps();
    load_digit(4'd9);
    @(negedge clk);
    hold_i        = 1'b1;
    digit_i       = 4'd2;
    lamp_test_n_i = 1'b0;
    @(posedge clk);
    #1;
    check("R3 lamp under hold", seg_o, 7'h7F);
    @(negedge clk);
    lamp_test_n_i = 1'b1;
    blank_n_i     = 1'b0;
    @(posedge clk);
    #1;
    check("R4 blank under hold", seg_o, 7'h00);
    @(negedge clk);
    lamp_test_n_i = 1'b0;
    #1;
    check("R3 lamp beats blank", seg_o, 7'h7F);
    @(negedge clk);
    lamp_test_n_i = 1'b1;
    blank_n_i     = 1'b1;
    @(posedge clk);
    #1;
    check("R7 stored kept after overrides", seg_o, glyph(4'd9));
    @(negedge clk);
    hold_i = 1'b0;
    @(posedge clk);
    #1;
    check("R1 capture after overrides", seg_o, glyph(4'd2));
  endtask

  task automatic t_pipe();
    load_digit(4'd3);
    check("R8 seg_q_o still old", seg_q_o, glyph(4'd2));
    @(negedge clk);
    digit_i = 4'd6;
    @(posedge clk);
    #1;
    check("R8 seg_q_o one cycle late", seg_q_o, glyph(4'd3));
    check("R5 six without top", seg_o, glyph(4'd6));
    @(posedge clk);
    #1;
    check("R8 seg_q_o follows", seg_q_o, glyph(4'd6));
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset seg_o", seg_o, 7'h3F);
    check("R9 async reset seg_q_o", seg_q_o, 7'h00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_sweep();
    t_hold();
    t_override_keeps();
    t_pipe();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule